// File: doc/BRIEF.md
# Two-Stage Calibration Scaler

This block turns a raw 24-bit converter result into the corrected word that is stored as channel data. The correction has two stages. The global stage removes a converter-wide offset and applies a converter-wide gain. The channel stage then removes a per-channel offset, given in sign-magnitude form, and applies a per-channel gain. When all coefficients are at their nominal values, both stages pass the code through unchanged. Unipolar and bipolar input ranges are supported. In bipolar mode the result is centred on the mid-code.

After the arithmetic, the corrected value is range-checked. Two flags are produced. The sign flag shows whether the input was negative. The over flag shows that the value fell outside the nominal code span on either side. An out-of-span value either wraps or saturates, depending on the clamp enable. A narrow mode returns only the upper 16 bits of the 24-bit code.

A conversion is launched with a one-cycle `start` strobe, which latches all operands. The result appears with a one-cycle `out_valid` pulse a fixed number of clock cycles later. The default is 163 cycles. Any `start` that arrives while a conversion is in progress is dropped.

Top module: `cal_scaler`

## Requirements
- R1: Unipolar, global stage: `s1 = ((raw - (g_zero - 800000h)) * g_gain) >>> 23`. Here `g_zero = 800000h` means zero offset and `g_gain = 800000h` means unity gain. `>>>` is an arithmetic (flooring) shift on a signed value of at least 48 bits.
- R2: Bipolar, global stage: `s1 = (((raw - (g_zero - 800000h) - 800000h) * g_gain) >>> 23) + 800000h`. With nominal coefficients, a mid-scale raw input (800000h) therefore gives exactly 800000h.
- R3: The channel offset `c_zero` is 23 bits wide. Bit 22 is the sign (1 = negative) and bits 21:0 are the magnitude. The offset value is ±magnitude, so a zero magnitude with either sign gives no offset.
- R4: Channel stage: `y = ((s1 - offset) * c_gain) >>> 21`, where `c_gain = 200000h` is unity gain.
- R5: `over_flag` is 1 exactly when `y < 0` or `y > FFFFFFh`.
- R6: `sign_flag` is 1 when the input is negative. In bipolar mode that means `y < 800000h`; in unipolar mode it means `y < 0`.
- R7: With `clamp_en = 1`, an out-of-span result saturates. It becomes 000000h when `y < 0` and FFFFFFh when `y > FFFFFFh`.
- R8: With `clamp_en = 0`, the code wraps to `y[23:0]`. For example, in bipolar narrow mode, one 16-bit LSB above full scale gives 0000h with `over_flag = 1`.
- R9: With `narrow = 1`, `data_out = {8'h00, code[23:8]}`. Otherwise `data_out` is the full 24-bit code.
- R10: `out_valid` pulses for exactly one cycle, CYCLES (163) clock edges after the edge that sampled `start`. The outputs hold their values until the next result.
- R11: A `start` that arrives while a conversion is in progress is ignored. It produces no extra result and does not change the pending one.
- R12: After reset, `out_valid`, `data_out`, `sign_flag` and `over_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch strobe; latches all operands when the block is idle |
| raw | input | 24 | Unsigned raw converter result |
| bipolar | input | 1 | 1 selects the bipolar range |
| narrow | input | 1 | 1 selects the 16-bit output |
| clamp_en | input | 1 | 1 saturates out-of-span results |
| g_zero | input | 24 | Global offset coefficient, nominal 800000h |
| g_gain | input | 24 | Global gain coefficient, nominal 800000h |
| c_zero | input | 23 | Channel offset in sign-magnitude form |
| c_gain | input | 24 | Channel gain coefficient, nominal 200000h |
| out_valid | output | 1 | One-cycle result strobe |
| data_out | output | 24 | Corrected code |
| sign_flag | output | 1 | Negative-input flag |
| over_flag | output | 1 | Out-of-span flag |

## Verification
The bench first runs nominal coefficients with unipolar and bipolar codes at zero, mid-scale, one below mid-scale and full scale. These cases separate the identity path from the mid-code re-centring.

It then moves each coefficient away from nominal on its own. A global offset, a global gain, a positive channel offset, a negative channel offset and a half channel gain each expose a single term of the formula. Pushing results just past either end of the span, with clamping on and off and in both output widths, separates saturation from wrap and the 24-bit code from the 16-bit code.

Finally, a sweep of mixed coefficient and mode combinations, together with a second start issued mid-conversion, checks the latency and the rule that a busy block drops new requests.

// File: rtl/cal_scale_pkg.sv
package cal_scale_pkg;

   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_t;

   typedef struct packed {
      logic sign;
      logic over;
   } range_flags_t;

endpackage

// File: rtl/cal_global_stage.sv
module cal_global_stage #(
   parameter int DW = 24,
   parameter int AW = 56
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [DW-1:0]        raw,
   input  logic                 bip,
   input  logic [DW-1:0]        gz,
   input  logic [DW-1:0]        gg,
   output logic signed [AW-1:0] s1
);
   localparam int PAD = AW - DW;
   localparam logic signed [AW-1:0] MID = {{PAD{1'b0}}, 1'b1, {(DW-1){1'b0}}};

   logic signed [AW-1:0] raw_s, zoff, gain, diff, prod, nxt, bias;

   always_comb begin
      raw_s = $signed({{PAD{1'b0}}, raw});
      zoff  = $signed({{PAD{1'b0}}, gz}) - MID;
      gain  = $signed({{PAD{1'b0}}, gg});
      bias  = bip ? MID : '0;
      diff  = raw_s - zoff - bias;
      prod  = diff * gain;
      nxt   = (prod >>> (DW-1)) + bias;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s1 <= '0;
      else if (load) s1 <= nxt;
   end

   // R2: nominal coefficients map mid-scale bipolar input onto the mid-code
   p_bip_mid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (load && bip && raw == MID[DW-1:0] && gz == MID[DW-1:0] && gg == MID[DW-1:0])
      |=> (s1 == MID));

endmodule

// File: rtl/cal_channel_stage.sv
module cal_channel_stage #(
   parameter int DW = 24,
   parameter int AW = 56
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic signed [AW-1:0] s1,
   input  logic [DW-2:0]        cz,
   input  logic [DW-1:0]        cg,
   output logic signed [AW-1:0] y
);
   localparam int MW  = DW - 2;
   localparam int SHF = DW - 3;

   logic signed [AW-1:0] mag, offs, gain, prod, nxt;

   always_comb begin
      mag  = $signed({{(AW-MW){1'b0}}, cz[MW-1:0]});
      offs = cz[DW-2] ? -mag : mag;
      gain = $signed({{(AW-DW){1'b0}}, cg});
      prod = (s1 - offs) * gain;
      nxt  = prod >>> SHF;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) y <= '0;
      else if (load) y <= nxt;
   end

   // R3/R4: zero offset with unity gain leaves the stage-one value unchanged
   p_unity_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (load && cz[MW-1:0] == '0 && cg == DW'(1) << SHF) |=> (y == $past(s1)));

endmodule

// File: rtl/cal_range_fmt.sv
module cal_range_fmt
   import cal_scale_pkg::*;
#(
   parameter int DW = 24,
   parameter int NW = 16,
   parameter int AW = 56
) (
   input  logic signed [AW-1:0] y,
   input  logic                 bip,
   input  logic                 narrow,
   input  logic                 clamp,
   output logic [DW-1:0]        data,
   output range_flags_t         flags
);
   localparam int PAD = AW - DW;
   localparam logic signed [AW-1:0] MID  = {{PAD{1'b0}}, 1'b1, {(DW-1){1'b0}}};
   localparam logic signed [AW-1:0] MAXV = {{PAD{1'b0}}, {DW{1'b1}}};

   logic          low, high;
   logic [DW-1:0] code;

   always_comb begin
      low        = (y < 0);
      high       = (y > MAXV);
      flags.over = low | high;
      flags.sign = bip ? (y < MID) : low;
      if (clamp && low)       code = '0;
      else if (clamp && high) code = '1;
      else                    code = y[DW-1:0];
   end

   generate
      if (NW < DW) begin : g_narrow
         assign data = narrow ? {{(DW-NW){1'b0}}, code[DW-1 -: NW]} : code;
      end else begin : g_full
         logic unused_narrow;
         assign unused_narrow = narrow;
         assign data = code;
      end
   endgenerate

endmodule

// File: rtl/cal_scaler.sv
module cal_scaler
   import cal_scale_pkg::*;
#(
   parameter int DW     = 24,
   parameter int NW     = 16,
   parameter int AW     = 2*DW + 8,
   parameter int CYCLES = 163
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] raw,
   input  logic          bipolar,
   input  logic          narrow,
   input  logic          clamp_en,
   input  logic [DW-1:0] g_zero,
   input  logic [DW-1:0] g_gain,
   input  logic [DW-2:0] c_zero,
   input  logic [DW-1:0] c_gain,
   output logic          out_valid,
   output logic [DW-1:0] data_out,
   output logic          sign_flag,
   output logic          over_flag
);
   localparam int CW = $clog2(CYCLES + 1);

   generate
      if (DW < 8)         begin : g_chk_dw  $error("DW too small");            end
      if (NW > DW)        begin : g_chk_nw  $error("NW exceeds DW");           end
      if (AW < 2*DW + 4)  begin : g_chk_aw  $error("AW too narrow");           end
      if (CYCLES < 3)     begin : g_chk_cyc $error("CYCLES must be at least 3"); end
   endgenerate

   seq_state_t    state;
   logic [CW-1:0] cnt;
   logic          busy, done, ld1, ld2;

   logic [DW-1:0] raw_q, gz_q, gg_q, cg_q;
   logic [DW-2:0] cz_q;
   logic          bip_q, nar_q, clamp_q;

   logic signed [AW-1:0] s1, y;
   logic [DW-1:0]        fmt_data;
   range_flags_t         fmt_flags;

   assign busy = (state == SEQ_RUN);
   assign done = busy && (cnt == CW'(CYCLES - 1));
   assign ld1  = busy && (cnt == CW'(0));
   assign ld2  = busy && (cnt == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         cnt   <= '0;
      end else if (!busy) begin
         if (start) begin
            state <= SEQ_RUN;
            cnt   <= '0;
         end
      end else if (done) begin
         state <= SEQ_IDLE;
      end else begin
         cnt <= cnt + CW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= '0; gz_q <= '0; gg_q <= '0; cz_q <= '0; cg_q <= '0;
         bip_q <= 1'b0; nar_q <= 1'b0; clamp_q <= 1'b0;
      end else if (!busy && start) begin
         raw_q <= raw; gz_q <= g_zero; gg_q <= g_gain; cz_q <= c_zero; cg_q <= c_gain;
         bip_q <= bipolar; nar_q <= narrow; clamp_q <= clamp_en;
      end
   end

   cal_global_stage #(.DW(DW), .AW(AW)) u_global (
      .clk(clk), .rst_n(rst_n), .load(ld1), .raw(raw_q), .bip(bip_q),
      .gz(gz_q), .gg(gg_q), .s1(s1)
   );

   cal_channel_stage #(.DW(DW), .AW(AW)) u_channel (
      .clk(clk), .rst_n(rst_n), .load(ld2), .s1(s1), .cz(cz_q), .cg(cg_q), .y(y)
   );

   cal_range_fmt #(.DW(DW), .NW(NW), .AW(AW)) u_fmt (
      .y(y), .bip(bip_q), .narrow(nar_q), .clamp(clamp_q),
      .data(fmt_data), .flags(fmt_flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         data_out  <= '0;
         sign_flag <= 1'b0;
         over_flag <= 1'b0;
      end else begin
         out_valid <= done;
         if (done) begin
            data_out  <= fmt_data;
            sign_flag <= fmt_flags.sign;
            over_flag <= fmt_flags.over;
         end
      end
   end

   // R10: the result strobe lasts one cycle
   p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R10: a result only ends a conversion that was running
   p_valid_after_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($past(busy) && !busy));

   // R6: a negative unipolar value is always out of span
   p_sign_over_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !bip_q && sign_flag) |-> over_flag);

   // R7: a clamped full-width out-of-span result is all zeros or all ones
   p_clamp_rail_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && clamp_q && over_flag && !nar_q) |-> (data_out == '0 || data_out == '1));

   // R11: operands do not move while a conversion runs
   p_hold_ops_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(raw_q) && $stable(cg_q)));

   generate
      if (NW < DW) begin : g_narrow_chk
         // R9: narrow results leave the upper byte clear
         p_narrow_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && nar_q) |-> (data_out[DW-1:NW] == '0));
      end
   endgenerate

endmodule

// File: tb/cal_scaler_test.sv
module cal_scaler_test;
   localparam int CYC = 163;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [23:0] raw = '0;
   logic        bipolar = 1'b0, narrow = 1'b0, clamp_en = 1'b0;
   logic [23:0] g_zero = 24'h800000, g_gain = 24'h800000, c_gain = 24'h200000;
   logic [22:0] c_zero = '0;
   logic        out_valid, sign_flag, over_flag;
   logic [23:0] data_out;

   int compared = 0, mismatched = 0;
   longint cyc = 0;

   typedef struct {
      logic [23:0] data;
      logic        sign;
      logic        over;
      longint      t0;
      string       tag;
   } exp_t;
   exp_t q[$];

   cal_scaler uut (
      .clk(clk), .rst_n(rst_n), .start(start), .raw(raw), .bipolar(bipolar),
      .narrow(narrow), .clamp_en(clamp_en), .g_zero(g_zero), .g_gain(g_gain),
      .c_zero(c_zero), .c_gain(c_gain), .out_valid(out_valid), .data_out(data_out),
      .sign_flag(sign_flag), .over_flag(over_flag)
   );

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string tag, input longint act, input longint exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic exp_t model(input logic [23:0] r, input logic b, input logic n,
                                  input logic c, input logic [23:0] gz, input logic [23:0] gg,
                                  input logic [22:0] cz, input logic [23:0] cg);
      exp_t e;
      longint mid, s, s1, off, y;
      logic [23:0] code;
      mid = 64'sh800000;
      s = longint'(r) - (longint'(gz) - mid);
      if (b) s1 = (((s - mid) * longint'(gg)) >>> 23) + mid;
      else   s1 = (s * longint'(gg)) >>> 23;
      off = cz[22] ? -longint'(cz[21:0]) : longint'(cz[21:0]);
      y = ((s1 - off) * longint'(cg)) >>> 21;
      e.over = (y < 0) || (y > 64'sh00FFFFFF);
      e.sign = b ? (y < mid) : (y < 0);
      if (c && y < 0) code = '0;
      else if (c && y > 64'sh00FFFFFF) code = '1;
      else code = y[23:0];
      e.data = n ? {8'h00, code[23:8]} : code;
      return e;
   endfunction

   task automatic launch(input string tag, input logic [23:0] r, input logic b, input logic n,
                         input logic c, input logic [23:0] gz, input logic [23:0] gg,
                         input logic [22:0] cz, input logic [23:0] cg);
      exp_t e;
      @(negedge clk);
      raw = r; bipolar = b; narrow = n; clamp_en = c;
      g_zero = gz; g_gain = gg; c_zero = cz; c_gain = cg;
      start = 1'b1;
      e = model(r, b, n, c, gz, gg, cz, cg);
      e.tag = tag;
      @(posedge clk);
      e.t0 = cyc + 1;
      q.push_back(e);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic run(input string tag, input logic [23:0] r, input logic b, input logic n,
                      input logic c, input logic [23:0] gz, input logic [23:0] gg,
                      input logic [22:0] cz, input logic [23:0] cg);
      launch(tag, r, b, n, c, gz, gg, cz, cg);
      repeat (CYC + 3) @(negedge clk);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (q.size() == 0) begin
            compared++; mismatched++;
            $display("FAIL R11 unexpected result actual=%0h expected=none", data_out);
         end else begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " data"}, data_out, e.data);
            check({e.tag, " sign R6"}, sign_flag, e.sign);
            check({e.tag, " over R5"}, over_flag, e.over);
            check({e.tag, " latency R10"}, cyc - e.t0, CYC);
         end
      end
   end

   initial begin
      #(4 * 150000);
      compared++; mismatched++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R12 reset valid", out_valid, 0);
      check("R12 reset data", data_out, 0);
      check("R12 reset flags", {sign_flag, over_flag}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // nominal coefficients
      run("R1 unipolar identity", 24'h123456, 0, 0, 0, 24'h800000, 24'h800000, 23'h0, 24'h200000);
      run("R1 unipolar full", 24'hFFFFFF, 0, 0, 0, 24'h800000, 24'h800000, 23'h0, 24'h200000);
      run("R2 bipolar mid", 24'h800000, 1, 0, 0, 24'h800000, 24'h800000, 23'h0, 24'h200000);
      run("R2 R9 bipolar mid narrow", 24'h800000, 1, 1, 0, 24'h800000, 24'h800000, 23'h0, 24'h200000);
      run("R6 bipolar below mid", 24'h7FFFFF, 1, 0, 0, 24'h800000, 24'h800000, 23'h0, 24'h200000);
      // single coefficient moves
      run("R1 global offset", 24'h400000, 0, 0, 0, 24'h800123, 24'h800000, 23'h0, 24'h200000);
      run("R1 global gain", 24'h400000, 0, 0, 0, 24'h800000, 24'h900000, 23'h0, 24'h200000);
      run("R2 bipolar global gain", 24'hA00000, 1, 0, 0, 24'h800000, 24'h700000, 23'h0, 24'h200000);
      run("R3 positive channel offset", 24'h400000, 0, 0, 0, 24'h800000, 24'h800000, 23'h000100, 24'h200000);
      run("R3 negative channel offset", 24'h400000, 0, 0, 0, 24'h800000, 24'h800000, 23'h400100, 24'h200000);
      run("R3 negative zero offset", 24'h345678, 0, 0, 0, 24'h800000, 24'h800000, 23'h400000, 24'h200000);
      run("R4 half channel gain", 24'h800000, 0, 0, 0, 24'h800000, 24'h800000, 23'h0, 24'h100000);
      // span edges
      run("R8 bipolar narrow wrap one over", 24'hFFFFFF, 1, 1, 0, 24'h800000, 24'h800000, 23'h400100, 24'h200000);
      run("R7 clamp high", 24'hFFFFFF, 1, 0, 1, 24'h800000, 24'h800000, 23'h400100, 24'h200000);
      run("R7 R9 clamp high narrow", 24'hFFFFFF, 0, 1, 1, 24'h800000, 24'h800000, 23'h400100, 24'h200000);
      run("R8 unipolar under wrap", 24'h000005, 0, 0, 0, 24'h80000A, 24'h800000, 23'h0, 24'h200000);
      run("R7 unipolar under clamp", 24'h000005, 0, 0, 1, 24'h80000A, 24'h800000, 23'h0, 24'h200000);
      run("R5 exactly full scale", 24'hFFFFFF, 0, 0, 1, 24'h800000, 24'h800000, 23'h0, 24'h200000);
      run("R5 exactly zero", 24'h000000, 0, 0, 1, 24'h800000, 24'h800000, 23'h0, 24'h200000);
      // mixed sweep
      for (int i = 0; i < 8; i++) begin
         logic [23:0] r;
         r = 24'((i * 24'h2F1A37) + 24'h1234);
         run("R1 R2 R4 sweep", r, i[0], i[1], i[2], 24'(24'h7FFF00 + i * 24'h61),
             24'(24'h7F0000 + i * 24'h3000), 23'((i * 23'h1357) | (i[0] ? 23'h400000 : 23'h0)),
             24'(24'h1F0000 + i * 24'h4000));
      end
      // R11: second start during a conversion is dropped
      launch("R11 first kept", 24'h222222, 0, 0, 0, 24'h800000, 24'h800000, 23'h0, 24'h200000);
      repeat (10) @(negedge clk);
      raw = 24'h999999; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (CYC + 20) @(negedge clk);
      check("R11 queue drained", q.size(), 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule